// File: doc/BRIEF.md
# Tracker Stub Segment Router

This block sorts a stream of tracker hit records ("stubs") into the sub-regions of one detector sector. It accepts one stub per clock. Each stub carries an eta coordinate, a phi coordinate, a signed local bend and an end-of-event flag. The block works out which eta slice the stub falls in and which phi slices its bend-widened phi window touches. It then writes the stub into the FIFO of every segment it belongs to. Every segment has its own valid/ready output stream. A stub near a phi boundary therefore appears in both neighbouring streams.

The eta decision is hierarchical. A coarse stage picks a group of eta slices. A second stage picks the slice inside that group and forms the phi window. Registers sit between the stages, so a stub is written into its FIFOs two clock edges after the block accepts it. The number of eta and phi slices, the eta group size, the bend-to-window scale and the FIFO depth are parameters. The slice boundaries are derived from these parameters.

An end-of-event record goes to every output, behind all stubs accepted before it. If a stub about to be written targets a full FIFO, the whole routing pipeline holds and the input stops accepting. No stub is ever dropped.

Top module: `stub_segment_router`

## Requirements
- R1: While reset is asserted and right after it is released, every `out_valid` bit is 0 and `in_ready` is 1.
- R2: The eta range 0..255 is split into NUM_ETA slices, where slice k starts at floor(k*256/NUM_ETA). A stub goes to the highest slice whose start is at or below its eta. It is delivered on output index eta_slice*NUM_PHI + phi_slice.
- R3: The phi range 0..1023 is split into NUM_PHI slices, where slice p starts at floor(p*1024/NUM_PHI). A stub with bend 0 goes to exactly one output: the slice that contains its phi.
- R4: A stub with non-zero bend covers the window [phi-w, phi+w], where w = |bend|*8 (bend is two's complement, 4 bits). An identical copy of the stub goes to every phi slice this window overlaps, including a window that ends exactly on a slice start.
- R5: The window is clipped to 0..1023 and never wraps. A stub near phi 0 with a large bend does not reach the top slice, and a stub near 1023 does not reach the bottom slice.
- R6: A record with `in_eoe`=1 is delivered unchanged on every output. On each output it comes after all records accepted before it.
- R7: Each output delivers exactly the records routed to it, in the order the input accepted them, and nothing else.
- R8: If the record in the routing stage targets a full FIFO, `in_ready` is 0 and every accepted record is kept. With every output stalled and all stubs aimed at one segment, exactly FIFO_DEPTH+2 stubs are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Input record taken on this edge when both are high |
| in_eta | input | 8 | Stub eta coordinate |
| in_phi | input | 10 | Stub phi coordinate |
| in_bend | input | 4 | Signed local bend |
| in_eoe | input | 1 | End-of-event record |
| out_valid | output | NSEG (36) | Per-segment record present |
| out_ready | input | NSEG (36) | Per-segment consumer ready |
| out_eta | output | NSEG*8 (288) | Segment i in bits [i*8 +: 8] |
| out_phi | output | NSEG*10 (360) | Segment i in bits [i*10 +: 10] |
| out_bend | output | NSEG*4 (144) | Segment i in bits [i*4 +: 4] |
| out_eoe | output | NSEG (36) | Per-segment end-of-event flag |

## Verification
The hardest case to reach is the routing stage stalled on a full FIFO while the coarse stage also holds a stub. The FIFO must be full, the stage must be holding, and the input must be refused, all at once. The bench reaches this by lowering every `out_ready` and aiming a burst of stubs at one segment. It counts how many stubs the input accepts before `in_ready` drops, then releases the outputs and checks that the burst drains in order. Boundary windows, such as a window that ends exactly on a phi slice start or is clipped at either end of the phi range, are reached with hand-picked phi and bend pairs. A random phase with random per-output ready then mixes duplication, end-of-event records and backpressure.

// File: rtl/stub_route_pkg.sv
package stub_route_pkg;
    localparam int ETA_W  = 8;
    localparam int PHI_W  = 10;
    localparam int BEND_W = 4;

    typedef struct packed {
        logic                     last;
        logic [ETA_W-1:0]         eta;
        logic [PHI_W-1:0]         phi;
        logic signed [BEND_W-1:0] bend;
    } stub_t;

    localparam int STUB_W = $bits(stub_t);
endpackage

// File: rtl/stub_seg_lookup.sv
module stub_seg_lookup
    import stub_route_pkg::*;
#(
    parameter int NUM_ETA    = 18,
    parameter int ETA_GRP    = 3,
    parameter int NUM_PHI    = 2,
    parameter int BEND_SHIFT = 3,
    localparam int NSEG      = NUM_ETA * NUM_PHI
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            in_valid,
    input  stub_t           in_stub,
    output logic            out_valid,
    output stub_t           out_stub,
    output logic [NSEG-1:0] out_mask
);
    localparam int NGRP     = NUM_ETA / ETA_GRP;
    localparam int GRP_W    = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int ETA_SPAN = 1 << ETA_W;
    localparam int PHI_SPAN = 1 << PHI_W;

    typedef struct packed {
        logic             valid;
        stub_t            stub;
        logic [GRP_W-1:0] grp;
    } coarse_t;

    typedef struct packed {
        logic            valid;
        stub_t           stub;
        logic [NSEG-1:0] mask;
    } route_t;

    typedef struct packed {
        coarse_t a;
        route_t  b;
    } state_t;

    state_t st_d, st_q;
    int grp_v, fine_v, eidx_v, bend_v, win_v, lo_v, hi_v;

    always_comb begin
        st_d   = st_q;
        grp_v  = 0;
        fine_v = 0;
        eidx_v = 0;
        bend_v = 0;
        win_v  = 0;
        lo_v   = 0;
        hi_v   = 0;
        if (advance) begin
            // coarse eta: pick the group
            for (int g = 1; g < NGRP; g++) begin
                if (int'(in_stub.eta) >= (g * ETA_GRP * ETA_SPAN) / NUM_ETA) grp_v = g;
            end
            st_d.a.valid = in_valid;
            st_d.a.stub  = in_stub;
            st_d.a.grp   = GRP_W'(grp_v);

            // fine eta: slice within the group held in stage a
            for (int g = 0; g < NGRP; g++) begin
                if (int'(st_q.a.grp) == g) begin
                    for (int j = 1; j < ETA_GRP; j++) begin
                        if (int'(st_q.a.stub.eta) >= ((g * ETA_GRP + j) * ETA_SPAN) / NUM_ETA)
                            fine_v = j;
                    end
                end
            end
            eidx_v = int'(st_q.a.grp) * ETA_GRP + fine_v;

            // phi window from bend, clipped to the sector
            bend_v = int'($signed(st_q.a.stub.bend));
            win_v  = (bend_v < 0 ? -bend_v : bend_v) << BEND_SHIFT;
            lo_v   = int'(st_q.a.stub.phi) - win_v;
            hi_v   = int'(st_q.a.stub.phi) + win_v;
            if (lo_v < 0) lo_v = 0;
            if (hi_v > PHI_SPAN - 1) hi_v = PHI_SPAN - 1;

            st_d.b.valid = st_q.a.valid;
            st_d.b.stub  = st_q.a.stub;
            st_d.b.mask  = '0;
            for (int p = 0; p < NUM_PHI; p++) begin
                if (hi_v >= (p * PHI_SPAN) / NUM_PHI && lo_v < ((p + 1) * PHI_SPAN) / NUM_PHI)
                    st_d.b.mask[eidx_v * NUM_PHI + p] = 1'b1;
            end
            if (st_q.a.stub.last) st_d.b.mask = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.b.valid;
    assign out_stub  = st_q.b.stub;
    assign out_mask  = st_q.b.mask;

    // R6: an end-of-event record in the routing stage targets every output
    assert_eoe_fanout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.b.valid && st_q.b.stub.last) |-> (&st_q.b.mask));

    // R3: a zero-bend stub lands in exactly one segment
    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.b.valid && !st_q.b.stub.last && st_q.b.stub.bend == '0)
            |-> ($countones(st_q.b.mask) == 1));

    // R4: every routed stub has at least one target
    assert_has_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.b.valid |-> ($countones(st_q.b.mask) >= 1));
endmodule

// File: rtl/stub_seg_fifo.sv
module stub_seg_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wr] = wdata;
            f_d.wr = (f_q.wr == PTR_W'(DEPTH - 1)) ? '0 : f_q.wr + 1'b1;
        end
        if (pop) begin
            f_d.rd = (f_q.rd == PTR_W'(DEPTH - 1)) ? '0 : f_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign full  = (f_q.cnt == CNT_W'(DEPTH));
    assign empty = (f_q.cnt == '0);
    assign rdata = f_q.mem[f_q.rd];

    // R8: the router never writes into a full buffer
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: the consumer never takes from an empty buffer
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/stub_segment_router.sv
module stub_segment_router
    import stub_route_pkg::*;
#(
    parameter int NUM_ETA    = 18,
    parameter int ETA_GRP    = 3,
    parameter int NUM_PHI    = 2,
    parameter int BEND_SHIFT = 3,
    parameter int FIFO_DEPTH = 4,
    localparam int NSEG      = NUM_ETA * NUM_PHI
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [ETA_W-1:0]       in_eta,
    input  logic [PHI_W-1:0]       in_phi,
    input  logic [BEND_W-1:0]      in_bend,
    input  logic                   in_eoe,
    output logic [NSEG-1:0]        out_valid,
    input  logic [NSEG-1:0]        out_ready,
    output logic [NSEG*ETA_W-1:0]  out_eta,
    output logic [NSEG*PHI_W-1:0]  out_phi,
    output logic [NSEG*BEND_W-1:0] out_bend,
    output logic [NSEG-1:0]        out_eoe
);
    stub_t           in_stub;
    stub_t           lk_stub;
    logic            lk_valid;
    logic [NSEG-1:0] lk_mask;
    logic [NSEG-1:0] full_vec;
    logic [NSEG-1:0] push_vec;
    logic            stall;
    logic            advance;

    always_comb begin
        in_stub.last = in_eoe;
        in_stub.eta  = in_eta;
        in_stub.phi  = in_phi;
        in_stub.bend = in_bend;
        stall        = lk_valid && |(lk_mask & full_vec);
        advance      = !stall;
        in_ready     = advance;
        push_vec     = (lk_valid && advance) ? lk_mask : '0;
    end

    stub_seg_lookup #(
        .NUM_ETA   (NUM_ETA),
        .ETA_GRP   (ETA_GRP),
        .NUM_PHI   (NUM_PHI),
        .BEND_SHIFT(BEND_SHIFT)
    ) i_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .in_valid (in_valid),
        .in_stub  (in_stub),
        .out_valid(lk_valid),
        .out_stub (lk_stub),
        .out_mask (lk_mask)
    );

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        stub_t head;
        logic  full_w;
        logic  empty_w;

        stub_seg_fifo #(
            .W    (STUB_W),
            .DEPTH(FIFO_DEPTH)
        ) i_fifo (
            .clk  (clk),
            .rst_n(rst_n),
            .push (push_vec[i]),
            .wdata(lk_stub),
            .pop  (out_ready[i] & ~empty_w),
            .full (full_w),
            .empty(empty_w),
            .rdata(head)
        );

        assign full_vec[i]                    = full_w;
        assign out_valid[i]                   = ~empty_w;
        assign out_eta[i*ETA_W +: ETA_W]      = head.eta;
        assign out_phi[i*PHI_W +: PHI_W]      = head.phi;
        assign out_bend[i*BEND_W +: BEND_W]   = head.bend;
        assign out_eoe[i]                     = head.last;
    end

    // R8: a blocked record stays in the routing stage unchanged
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall) |-> (lk_valid && $stable(lk_stub) && $stable(lk_mask)));
endmodule

// File: tb/test_stub_segment_router.sv
`timescale 1ns/1ps
module test_stub_segment_router;
    import stub_route_pkg::*;

    localparam int NUM_ETA    = 18;
    localparam int NUM_PHI    = 2;
    localparam int FIFO_DEPTH = 4;
    localparam int NSEG       = NUM_ETA * NUM_PHI;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [7:0]             in_eta = '0;
    logic [9:0]             in_phi = '0;
    logic [3:0]             in_bend = '0;
    logic                   in_eoe = 1'b0;
    logic [NSEG-1:0]        out_valid;
    logic [NSEG-1:0]        rdy = '1;
    logic [NSEG*8-1:0]      out_eta;
    logic [NSEG*10-1:0]     out_phi;
    logic [NSEG*4-1:0]      out_bend;
    logic [NSEG-1:0]        out_eoe;

    int    total = 0;
    int    bad = 0;
    int    accepted = 0;
    bit    rand_on = 1'b0;
    string tag = "R7";
    stub_t exp_q[NSEG][$];

    always #2.5 clk = ~clk;

    stub_segment_router i_stub_segment_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_eta(in_eta), .in_phi(in_phi), .in_bend(in_bend), .in_eoe(in_eoe),
        .out_valid(out_valid), .out_ready(rdy), .out_eta(out_eta),
        .out_phi(out_phi), .out_bend(out_bend), .out_eoe(out_eoe)
    );

    function automatic logic [NSEG-1:0] model(stub_t s);
        logic [NSEG-1:0] m;
        int e, b, w, lo, hi;
        m = '0;
        if (s.last) return '1;
        e = 0;
        for (int k = 1; k < NUM_ETA; k++) if (int'(s.eta) >= (k * 256) / NUM_ETA) e = k;
        b  = int'($signed(s.bend));
        w  = (b < 0 ? -b : b) * 8;
        lo = int'(s.phi) - w;
        hi = int'(s.phi) + w;
        if (lo < 0) lo = 0;
        if (hi > 1023) hi = 1023;
        for (int p = 0; p < NUM_PHI; p++)
            if (hi >= (p * 1024) / NUM_PHI && lo < ((p + 1) * 1024) / NUM_PHI) m[e*NUM_PHI+p] = 1'b1;
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int e, input int p, input int b, input bit l);
        stub_t s;
        logic [NSEG-1:0] m;
        s.last = l; s.eta = 8'(e); s.phi = 10'(p); s.bend = 4'(b);
        m = model(s);
        for (int i = 0; i < NSEG; i++) if (m[i]) exp_q[i].push_back(s);
        @(negedge clk);
        in_valid = 1'b1; in_eta = s.eta; in_phi = s.phi; in_bend = s.bend; in_eoe = l;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        accepted++;
        #1 in_valid = 1'b0;
    endtask

    task automatic set_rdy(input logic [NSEG-1:0] v);
        @(posedge clk);
        #1 rdy = v;
    endtask

    task automatic drain(input string req);
        int left;
        for (int c = 0; c < 3000; c++) begin
            left = 0;
            for (int i = 0; i < NSEG; i++) left += exp_q[i].size();
            if (left == 0) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        left = 0;
        for (int i = 0; i < NSEG; i++) left += exp_q[i].size();
        check(left == 0, {req, " missing records"}, left, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: compare every delivered record against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < NSEG; i++) begin
                if (out_valid[i] && rdy[i]) begin
                    stub_t got, exp;
                    got.last = out_eoe[i];
                    got.eta  = out_eta[i*8 +: 8];
                    got.phi  = out_phi[i*10 +: 10];
                    got.bend = out_bend[i*4 +: 4];
                    total++;
                    if (exp_q[i].size() == 0) begin
                        bad++;
                        $display("FAIL %s seg %0d unexpected actual=%h expected=none", tag, i, got);
                    end else begin
                        exp = exp_q[i].pop_front();
                        if (got !== exp) begin
                            bad++;
                            $display("FAIL %s seg %0d actual=%h expected=%h", tag, i, got, exp);
                        end
                    end
                end
            end
        end
    end

    // random per-output ready
    initial begin
        forever begin
            @(posedge clk);
            #1 if (rand_on) rdy = NSEG'({$urandom(), $urandom()});
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R1 out_valid in reset", int'($countones(out_valid)), 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0, "R1 out_valid after reset", int'($countones(out_valid)), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R2: each eta slice start and the value just below it
        tag = "R2";
        for (int k = 0; k < NUM_ETA; k++) begin
            send((k * 256) / NUM_ETA, 100, 0, 1'b0);
            if (k > 0) send((k * 256) / NUM_ETA - 1, 700, 0, 1'b0);
        end
        send(255, 300, 0, 1'b0);
        drain("R2");

        // R3: zero bend at the phi extremes and around the slice start
        tag = "R3";
        send(20, 0, 0, 1'b0);
        send(20, 511, 0, 1'b0);
        send(20, 512, 0, 1'b0);
        send(20, 1023, 0, 1'b0);
        drain("R3");

        // R4: windows near the phi slice start
        tag = "R4";
        send(60, 510, 1, 1'b0);
        send(60, 520, -1, 1'b0);
        send(60, 505, 1, 1'b0);
        send(60, 504, 1, 1'b0);
        send(60, 503, 1, 1'b0);
        send(60, 540, -4, 1'b0);
        drain("R4");

        // R5: clipped windows at both ends of the phi range
        tag = "R5";
        send(130, 3, -8, 1'b0);
        send(130, 1020, 7, 1'b0);
        send(130, 0, 7, 1'b0);
        drain("R5");

        // R6: end-of-event behind earlier stubs on every output
        tag = "R6";
        send(10, 100, 0, 1'b0);
        send(200, 900, 2, 1'b0);
        send(77, 500, 3, 1'b0);
        send(0, 0, 0, 1'b1);
        drain("R6");

        // R8: all outputs stalled, burst into one segment
        tag = "R8";
        set_rdy('0);
        accepted = 0;
        fork
            begin
                for (int n = 0; n < FIFO_DEPTH + 3; n++) send(50, 100 + n, 0, 1'b0);
            end
            begin
                repeat (25) @(negedge clk);
                check(in_ready == 1'b0, "R8 in_ready while blocked", int'(in_ready), 0);
                check(accepted == FIFO_DEPTH + 2, "R8 accepted before stall", accepted, FIFO_DEPTH + 2);
                check(out_valid[6] == 1'b1, "R8 head waiting", int'(out_valid[6]), 1);
                set_rdy('1);
            end
        join
        drain("R8");

        // R7: random stream with random per-output ready
        tag = "R7";
        rand_on = 1'b1;
        for (int n = 0; n < 120; n++)
            send(int'($urandom_range(0, 255)), int'($urandom_range(0, 1023)),
                 int'($urandom_range(0, 15)) - 8, ($urandom_range(0, 15) == 0));
        drain("R7");
        rand_on = 1'b0;
        set_rdy('1);
        repeat (5) @(negedge clk);
        check(out_valid == '0, "R7 nothing extra", int'($countones(out_valid)), 0);

        finish_run();
    end
endmodule